// File: doc/BRIEF.md
# Strided IDE Register Window Decoder

This block is a memory-mapped slave that turns accesses into a 4 KB window into strobes toward an IDE task-file register bank. The bank sits behind an abstract port model. The bank presents the current contents of its registers on view inputs and takes registered select strobes plus write data. Registers are spaced 16 bytes apart. Only bits [11:4] of the bus address choose a register. The bits below the stride and the bits above the window are ignored.

There are three kinds of register. The seven 8-bit task-file registers take byte accesses only. The device-control / alternate-status pair is an 8-bit register that answers at two separate indices. The data port takes only halfword and word accesses. The data port swaps byte lanes in both directions, so bus byte order and device byte order stay consistent. Locations that map to nothing give all ones at the access width on a read and ignore a write. Every read gets exactly one response, one cycle after the request.

Top module: `ide_win_decode`

## Requirements
- R1: The register index is `req_addr[11:4]`. Address bits [3:0] and bits above bit 11 have no effect on which register is selected or on the data returned.
- R2: A byte access (`req_size` = 0) to index 1..7 pulses `bk_tf_wr` (write) or `bk_tf_rd` (read), with `bk_tf_idx` equal to the index. A write carries `req_wdata[7:0]` zero-extended on `bk_wdata`. A read returns the matching byte of `tf_view`, where index i is `tf_view[8*(i-1)+:8]`, zero-extended.
- R3: A byte access to index 8 or index 22 pulses `bk_ctl_wr` on a write, with the byte on `bk_wdata`. On a read it pulses `bk_alt_rd` and returns `alt_view` zero-extended.
- R4: A halfword (`req_size` = 1) or word (`req_size` = 2) write to index 0 pulses `bk_dat_wr`. `bk_dat_wide` is 1 for a word and 0 for a halfword. `bk_wdata` carries the low 2 or 4 bytes of `req_wdata` in reversed byte order, with the upper bytes zero.
- R5: A halfword or word read of index 0 pulses `bk_dat_rd` with `bk_dat_wide` set as in R4. It returns the low 2 or 4 bytes of `dat_view` in reversed byte order, zero-extended.
- R6: A read of any other location returns all ones at the access width: 0x000000FF for a byte, 0x0000FFFF for a halfword, and 0xFFFFFFFF for a word or for the reserved size code 3. No bank strobe pulses.
- R7: A write to any other location, including a byte write to index 0, a halfword or word write to a nonzero index, and any size-3 write, pulses no bank strobe.
- R8: Strobes and `rsp_valid` appear in the cycle after the request and last one cycle. At most one bank strobe is high in any cycle. `rsp_valid` pulses once for each read and never for a write.
- R9: While `rst` is high, all strobes, `rsp_valid` and `rsp_rdata` are zero, and a request made during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Bus byte address |
| req_wdata | input | DATA_W | Write data, least significant lanes used |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| bk_tf_wr | output | 1 | Task-file register write strobe |
| bk_tf_rd | output | 1 | Task-file register read strobe |
| bk_tf_idx | output | 3 | Task-file register number 1..7 |
| bk_ctl_wr | output | 1 | Device-control write strobe |
| bk_alt_rd | output | 1 | Alternate-status read strobe |
| bk_dat_wr | output | 1 | Data port write strobe |
| bk_dat_rd | output | 1 | Data port read strobe |
| bk_dat_wide | output | 1 | Data port access is 32-bit |
| bk_wdata | output | DATA_W | Write data toward the bank |
| tf_view | input | 56 | Current task-file registers 1..7 |
| alt_view | input | 8 | Current alternate-status value |
| dat_view | input | DATA_W | Next data-port word in device order |

## Verification
On every cycle, the assertions check the timing and exclusivity rules. At most one strobe fires at a time. Each read is followed by exactly one response and writes never get one. Strobes never fire for rejected sizes, and the data-port width flag follows the request size. The values themselves can only be shown by the bench's sweep, which walks every index under every size in both directions. Those values are the alias pair, the swapped lanes, the width-dependent all-ones hole value, the silent discard of stray writes and the masking of address bits outside [11:4]. The bench also asserts reset in the middle of a request.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_HOLE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } tgt_e;
endpackage

// File: rtl/ide_win_addr_dec.sv
module ide_win_addr_dec
  import ide_win_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int TF_FIRST  = 1,
  parameter int TF_LAST   = 7,
  parameter int CTL_IDX_A = 8,
  parameter int CTL_IDX_B = 22,
  parameter int DATA_IDX  = 0,
  localparam int TF_IDX_W = $clog2(TF_LAST + 1)
) (
  input  logic [IDX_W-1:0]    idx,
  input  acc_size_e           size,
  output tgt_e                tgt,
  output logic [TF_IDX_W-1:0] tf_idx
);
  always_comb begin
    tgt    = TGT_HOLE;
    tf_idx = idx[TF_IDX_W-1:0];
    if (size == SZ_BYTE) begin
      if (int'(idx) >= TF_FIRST && int'(idx) <= TF_LAST)
        tgt = TGT_TASK;
      else if (int'(idx) == CTL_IDX_A || int'(idx) == CTL_IDX_B)
        tgt = TGT_CTRL;
    end else if (size == SZ_HALF || size == SZ_WORD) begin
      if (int'(idx) == DATA_IDX)
        tgt = TGT_DATA;
    end
  end
endmodule

// File: rtl/ide_win_lane_swap.sv
module ide_win_lane_swap #(
  parameter int BYTES = 4,
  localparam int W    = BYTES * 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/ide_win_rd_mux.sv
module ide_win_rd_mux
  import ide_win_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TF_REGS  = 7,
  parameter int TF_IDX_W = 3
) (
  input  tgt_e                  tgt,
  input  acc_size_e             size,
  input  logic [TF_IDX_W-1:0]   tf_idx,
  input  logic [TF_REGS*8-1:0]  tf_view,
  input  logic [7:0]            alt_view,
  input  logic [15:0]           dat_sw16,
  input  logic [31:0]           dat_sw32,
  output logic [DATA_W-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    unique case (tgt)
      TGT_TASK: rdata[7:0]  = tf_view[(int'(tf_idx) - 1) * 8 +: 8];
      TGT_CTRL: rdata[7:0]  = alt_view;
      TGT_DATA: begin
        if (size == SZ_WORD) rdata[31:0] = dat_sw32;
        else                 rdata[15:0] = dat_sw16;
      end
      default: begin
        unique case (size)
          SZ_BYTE: rdata[7:0]  = 8'hFF;
          SZ_HALF: rdata[15:0] = 16'hFFFF;
          default: rdata[31:0] = 32'hFFFF_FFFF;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WIN_W      = 12,
  parameter int STRIDE_LSB = 4,
  parameter int TF_REGS    = 7,
  parameter int CTL_IDX_A  = 8,
  parameter int CTL_IDX_B  = 22,
  localparam int IDX_W     = WIN_W - STRIDE_LSB,
  localparam int TF_IDX_W  = $clog2(TF_REGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 bk_tf_wr,
  output logic                 bk_tf_rd,
  output logic [TF_IDX_W-1:0]  bk_tf_idx,
  output logic                 bk_ctl_wr,
  output logic                 bk_alt_rd,
  output logic                 bk_dat_wr,
  output logic                 bk_dat_rd,
  output logic                 bk_dat_wide,
  output logic [DATA_W-1:0]    bk_wdata,
  input  logic [TF_REGS*8-1:0] tf_view,
  input  logic [7:0]           alt_view,
  input  logic [DATA_W-1:0]    dat_view
);
  acc_size_e             size;
  tgt_e                  tgt;
  logic [TF_IDX_W-1:0]   tf_idx;
  logic [15:0]           wr_sw16, rd_sw16;
  logic [31:0]           wr_sw32, rd_sw32;
  logic [DATA_W-1:0]     rd_next, wd_next;
  logic                  is_rd, is_wr;

  assign size  = acc_size_e'(req_size);
  assign is_rd = req_valid && !req_write;
  assign is_wr = req_valid && req_write;

  ide_win_addr_dec #(
    .IDX_W(IDX_W), .TF_FIRST(1), .TF_LAST(TF_REGS),
    .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B), .DATA_IDX(0)
  ) u_dec (
    .idx(req_addr[WIN_W-1:STRIDE_LSB]), .size(size), .tgt(tgt), .tf_idx(tf_idx)
  );

  ide_win_lane_swap #(.BYTES(2)) u_wsw16 (.din(req_wdata[15:0]), .dout(wr_sw16));
  ide_win_lane_swap #(.BYTES(4)) u_wsw32 (.din(req_wdata[31:0]), .dout(wr_sw32));
  ide_win_lane_swap #(.BYTES(2)) u_rsw16 (.din(dat_view[15:0]),  .dout(rd_sw16));
  ide_win_lane_swap #(.BYTES(4)) u_rsw32 (.din(dat_view[31:0]),  .dout(rd_sw32));

  ide_win_rd_mux #(
    .DATA_W(DATA_W), .TF_REGS(TF_REGS), .TF_IDX_W(TF_IDX_W)
  ) u_mux (
    .tgt(tgt), .size(size), .tf_idx(tf_idx), .tf_view(tf_view),
    .alt_view(alt_view), .dat_sw16(rd_sw16), .dat_sw32(rd_sw32), .rdata(rd_next)
  );

  always_comb begin
    wd_next = '0;
    if (tgt == TGT_DATA) begin
      if (size == SZ_WORD) wd_next[31:0] = wr_sw32;
      else                 wd_next[15:0] = wr_sw16;
    end else begin
      wd_next[7:0] = req_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      bk_tf_wr    <= 1'b0;
      bk_tf_rd    <= 1'b0;
      bk_tf_idx   <= '0;
      bk_ctl_wr   <= 1'b0;
      bk_alt_rd   <= 1'b0;
      bk_dat_wr   <= 1'b0;
      bk_dat_rd   <= 1'b0;
      bk_dat_wide <= 1'b0;
      bk_wdata    <= '0;
    end else begin
      rsp_valid <= is_rd;
      if (is_rd) rsp_rdata <= rd_next;
      bk_tf_wr    <= is_wr && tgt == TGT_TASK;
      bk_tf_rd    <= is_rd && tgt == TGT_TASK;
      bk_ctl_wr   <= is_wr && tgt == TGT_CTRL;
      bk_alt_rd   <= is_rd && tgt == TGT_CTRL;
      bk_dat_wr   <= is_wr && tgt == TGT_DATA;
      bk_dat_rd   <= is_rd && tgt == TGT_DATA;
      bk_tf_idx   <= tf_idx;
      bk_dat_wide <= size == SZ_WORD;
      if (is_wr) bk_wdata <= wd_next;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bk_tf_wr, bk_tf_rd, bk_ctl_wr, bk_alt_rd, bk_dat_wr, bk_dat_rd})); // R8
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid); // R8
  AST_RSVD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd3) |=>
      !(bk_tf_wr || bk_tf_rd || bk_ctl_wr || bk_alt_rd || bk_dat_wr || bk_dat_rd)); // R7
  AST_CTL_BYTE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != 2'd0) |=> !(bk_ctl_wr || bk_alt_rd || bk_tf_wr || bk_tf_rd)); // R3
  AST_WIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd2) |=> bk_dat_wide); // R4
endmodule

// File: tb/sim_ide_win_decode.sv
module sim_ide_win_decode;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata, bk_wdata;
  logic        bk_tf_wr, bk_tf_rd, bk_ctl_wr, bk_alt_rd, bk_dat_wr, bk_dat_rd, bk_dat_wide;
  logic [2:0]  bk_tf_idx;
  logic [55:0] tf_view;
  logic [7:0]  alt_view;
  logic [31:0] dat_view;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ide_win_decode u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bk_tf_wr(bk_tf_wr),
    .bk_tf_rd(bk_tf_rd), .bk_tf_idx(bk_tf_idx), .bk_ctl_wr(bk_ctl_wr),
    .bk_alt_rd(bk_alt_rd), .bk_dat_wr(bk_dat_wr), .bk_dat_rd(bk_dat_rd),
    .bk_dat_wide(bk_dat_wide), .bk_wdata(bk_wdata), .tf_view(tf_view),
    .alt_view(alt_view), .dat_view(dat_view)
  );

  function automatic logic [31:0] rev(input logic [31:0] x, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r = r | (((x >> (8 * i)) & 32'hFF) << (8 * (n - 1 - i)));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {bk_tf_wr, bk_tf_rd, bk_ctl_wr, bk_alt_rd, bk_dat_wr, bk_dat_rd};
  endfunction

  task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string tag);
    int idx;
    bit tsk, ctl, dat;
    logic [5:0] es;
    logic [31:0] er;
    string lbl;
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    idx = int'(a[11:4]);
    tsk = sz == 0 && idx >= 1 && idx <= 7;
    ctl = sz == 0 && (idx == 8 || idx == 22);
    dat = (sz == 1 || sz == 2) && idx == 0;
    lbl = tsk ? "R2" : ctl ? "R3" : dat ? (w ? "R4" : "R5") : (w ? "R7" : "R6");
    if (tag != "") lbl = tag;
    es = {tsk && w, tsk && !w, ctl && w, ctl && !w, dat && w, dat && !w};
    chk({rsp_valid, strobes()} == {!w, es}, {lbl, " strobes/R8"},
        {25'd0, rsp_valid, strobes()}, {25'd0, !w, es});
    if (tsk) chk(bk_tf_idx == idx[2:0], {lbl, " index"}, {29'd0, bk_tf_idx}, idx);
    if (dat) chk(bk_dat_wide == (sz == 2), {lbl, " wide"}, {31'd0, bk_dat_wide}, {31'd0, sz == 2});
    if (w && (tsk || ctl)) chk(bk_wdata == (wd & 32'hFF), {lbl, " wdata"}, bk_wdata, wd & 32'hFF);
    if (w && dat) begin
      er = rev(wd, sz == 2 ? 4 : 2);
      chk(bk_wdata == er, {lbl, " wdata"}, bk_wdata, er);
    end
    if (!w) begin
      if (tsk) er = (tf_view >> (8 * (idx - 1))) & 56'hFF;
      else if (ctl) er = {24'd0, alt_view};
      else if (dat) er = rev(dat_view, sz == 2 ? 4 : 2);
      else er = sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
      chk(rsp_rdata == er, {lbl, " rdata"}, rsp_rdata, er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 7; i++) tf_view[8*(i-1) +: 8] = 8'(8'h30 + 7 * i);
    alt_view = 8'h5A;
    dat_view = 32'h1122_3344;
    rst = 1; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    chk({rsp_valid, strobes()} == 7'd0 && rsp_rdata == 0, "R9 reset state",
        {25'd0, rsp_valid, strobes()}, 32'd0);
    rst = 0;
    // R1: upper and sub-stride bits must not matter
    access(0, 2'd0, 32'h7FFF_F03F, 32'd0, "R1");
    access(1, 2'd1, 32'hA5A5_A00E, 32'hBEEF_CAFE, "R1");
    // near-exhaustive sweep: every index, every size, both directions
    for (int s = 0; s < 4; s++)
      for (int ix = 0; ix < 256; ix++)
        for (int w = 0; w < 2; w++)
          access(w[0], s[1:0], {20'hC3A50 ^ 20'(ix * 13), ix[7:0], 4'(ix + s)},
                 32'hD00D_0000 | 32'(ix << 4) | 32'(s * 32'h0101_0000), "");
    // R8: strobes last one cycle
    access(0, 2'd0, 32'h20, 32'd0, "");
    @(negedge clk);
    chk({rsp_valid, strobes()} == 7'd0, "R8 one-cycle", {25'd0, rsp_valid, strobes()}, 32'd0);
    // R9: request issued during reset has no effect
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 0; req_addr = 32'h10; rst = 1;
    @(negedge clk);
    req_valid = 0; rst = 0;
    chk({rsp_valid, strobes()} == 7'd0 && rsp_rdata == 0, "R9 mid-request reset",
        {25'd0, rsp_valid, strobes()}, 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule